// File: doc/BRIEF.md
# USB Host Pipe Double-Bank Controller

This block holds the state of one USB host pipe that owns two data banks. It counts how many banks hold data, tells software and the transaction engine which bank each should touch next, and keeps the DATA0/DATA1 toggle. For an OUT pipe the toggle is the next one to transmit. For an IN pipe it is the one last received.

When an OUT data phase starts on a periodic pipe (isochronous or interrupt) and no bank holds data, the engine sends a zero-length packet. The block then raises a sticky underflow flag, and that flag drives an interrupt when its enable is set. For IN pipes a programmed request count N allows N+1 successful IN transactions. After the last one the pipe freezes and withholds tokens until software releases it.

Software sees an 8-bit status byte. It clears flags by writing 0 to their positions; writing 1 leaves them alone. The transaction engine reports each data phase and each successful handshake with single-cycle strobes. Bank memory contents are not part of this block.

Top module: `hpipe_bank_ctrl`

## Requirements
- R1: Status bits [1:0] give the busy-bank count: 00 = none, 01 = one, 10 = two. The count saturates at two and never reads 11. A fill while both banks are busy is ignored, and so is a free while none are busy.
- R2: On an OUT pipe each `sw_fill` adds one busy bank. Each acknowledged OUT that carried data removes one. `sw_bank` and `eng_bank` each advance through banks 0,1,0,... starting at 0.
- R3: On an IN pipe an acknowledged data packet fills the bank at `eng_bank`, and `sw_free` releases the bank at `sw_bank`. Data received while both banks are busy is dropped and changes neither the count, the toggle nor the request counter.
- R4: Status bits [3:2] give the toggle: 00 = DATA0, 01 = DATA1. Bit 3 is always 0 and the reset value is 00.
- R5: On an OUT pipe the toggle inverts once per acknowledged OUT transaction, including a zero-length one. Without an acknowledgement it does not change.
- R6: On an IN pipe the toggle equals the PID (`eng_in_pid`, 0 = DATA0, 1 = DATA1) of the last acknowledged data packet that was stored.
- R7: An OUT data phase on a periodic pipe with no busy bank (`bank_empty` high) sets the underflow flag, status bit 5, and leaves the busy count alone. On a non-periodic pipe the same event sets no flag, and its acknowledgement leaves the toggle unchanged.
- R8: `irq` is high exactly when the underflow flag is set and `cfg_ie` was high at the edge that produced the flag's current value.
- R9: A status write with `flag_wdata[0]`=0 clears underflow and with `flag_wdata[1]`=0 clears freeze (status bit 6). Writing 1 has no effect, and a hardware set in the same cycle wins over a clear.
- R10: `cnt_rd` shows the programmed request count, which drops by one on each successful IN. A successful IN while the count is 0 freezes the pipe, so N+1 successful requests precede the freeze.
- R11: While frozen, `tok_allow` is low and all engine strobes are ignored, until software clears the freeze.
- R12: Status bits 4 and 7 always read 0. After reset the status byte is 0, `cnt_rd` is 0 and `tok_allow` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir_in | input | 1 | 1 = IN pipe, 0 = OUT pipe |
| cfg_periodic | input | 1 | Pipe is isochronous or interrupt |
| cfg_ie | input | 1 | Underflow interrupt enable |
| cnt_wr | input | 1 | Load the IN request count |
| cnt_wdata | input | CNT_W | Request count value |
| stat_wr | input | 1 | Status flag write strobe |
| flag_wdata | input | 2 | Write value: [0] underflow, [1] freeze |
| sw_fill | input | 1 | Software filled a bank (OUT) |
| sw_free | input | 1 | Software released a bank (IN) |
| eng_out_sent | input | 1 | Engine started an OUT data phase |
| eng_in_rcvd | input | 1 | Engine received an IN data packet |
| eng_in_pid | input | 1 | PID of that packet, 1 = DATA1 |
| eng_ack | input | 1 | Current transaction completed successfully |
| stat_rd | output | 8 | Status byte |
| cnt_rd | output | CNT_W | Remaining IN request count |
| eng_bank | output | PTR_W | Bank the engine uses next |
| sw_bank | output | PTR_W | Bank software uses next |
| bank_empty | output | 1 | No bank busy (send zero-length on OUT) |
| tok_allow | output | 1 | Engine may issue tokens |
| irq | output | 1 | Underflow interrupt |

## Verification
The hardest situations to reach are collisions and saturated states. One is a hardware underflow set landing in the same cycle as a software clear. The others are an IN packet arriving while both banks are busy, and engine traffic arriving after the freeze has already taken effect. Directed sequences drive the request count down to zero and fill both banks before sending more data. They also issue the clear write on the exact cycle of an empty OUT data phase. A behavioural model is compared against every output on every clock.

// File: rtl/hpipe_pkg.sv
package hpipe_pkg;
  // kind of data phase waiting for its handshake
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_DATA = 2'd1,
    PEND_ZERO = 2'd2
  } pend_e;

  localparam int STAT_W       = 8;
  localparam int STAT_UF_BIT  = 5;
  localparam int STAT_FRZ_BIT = 6;
endpackage

// File: rtl/hpipe_bank_track.sv
module hpipe_bank_track #(
  parameter int NUM_BANKS = 2,
  localparam int PTR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BUSY_W = $clog2(NUM_BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              dec,
  output logic [BUSY_W-1:0] busy,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              empty,
  output logic              full
);
  localparam logic [BUSY_W-1:0] BUSY_MAX = BUSY_W'(NUM_BANKS);
  localparam logic [PTR_W-1:0]  PTR_LAST = PTR_W'(NUM_BANKS - 1);

  logic [BUSY_W-1:0] busy_q, busy_d;
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic              inc_ok, dec_ok;

  assign empty  = (busy_q == '0);
  assign full   = (busy_q == BUSY_MAX);
  assign inc_ok = inc && !full;
  assign dec_ok = dec && !empty;

  always_comb begin
    case ({inc_ok, dec_ok})
      2'b10:   busy_d = busy_q + BUSY_W'(1);
      2'b01:   busy_d = busy_q - BUSY_W'(1);
      default: busy_d = busy_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      if (inc_ok) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + PTR_W'(1);
      if (dec_ok) rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + PTR_W'(1);
    end
  end

  assign busy   = busy_q;
  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;

  // R1: occupancy never passes the bank count
  p_busy_bound_r1: assert property (@(posedge clk) disable iff (rst)
    busy_q <= BUSY_MAX);
  // R2: a lone accepted fill adds exactly one busy bank
  p_busy_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (inc_ok && !dec_ok) |=> busy_q == $past(busy_q) + BUSY_W'(1));
  // R1: a free request on empty occupancy leaves it at zero
  p_no_underrun_r1: assert property (@(posedge clk) disable iff (rst)
    (empty && !inc) |=> busy_q == '0);
endmodule

// File: rtl/hpipe_toggle.sv
module hpipe_toggle (
  input  logic clk,
  input  logic rst,
  input  logic dir_in,
  input  logic out_adv,
  input  logic in_load,
  input  logic in_pid,
  output logic tgl
);
  logic tgl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_q <= 1'b0;
    end else if (!dir_in && out_adv) begin
      tgl_q <= ~tgl_q;
    end else if (dir_in && in_load) begin
      tgl_q <= in_pid;
    end
  end

  assign tgl = tgl_q;

  // R5: an acknowledged OUT inverts the toggle
  p_out_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (!dir_in && out_adv) |=> tgl_q != $past(tgl_q));
  // R6: a stored IN packet leaves its PID in the toggle
  p_in_pid_r6: assert property (@(posedge clk) disable iff (rst)
    (dir_in && in_load) |=> tgl_q == $past(in_pid));
  // R5: no event, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!out_adv && !in_load) |=> $stable(tgl_q));
endmodule

// File: rtl/hpipe_inreq_ctr.sv
module hpipe_inreq_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             frz_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             frozen
);
  logic [CNT_W-1:0] cnt_q;
  logic             frz_q;
  logic             last_req;

  assign last_req = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      frz_q <= 1'b0;
    end else begin
      if (load)                       cnt_q <= load_val;
      else if (step && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
      if (last_req)                   frz_q <= 1'b1;
      else if (frz_clr)               frz_q <= 1'b0;
    end
  end

  assign cnt    = cnt_q;
  assign frozen = frz_q;

  // R10: the request taken at count zero freezes the pipe
  p_freeze_at_zero_r10: assert property (@(posedge clk) disable iff (rst)
    last_req |=> frz_q);
  // R10: each successful IN above zero counts down by one
  p_count_down_r10: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/hpipe_bank_ctrl.sv
module hpipe_bank_ctrl
  import hpipe_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int CNT_W = 8,
  localparam int PTR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BUSY_W = $clog2(NUM_BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_dir_in,
  input  logic              cfg_periodic,
  input  logic              cfg_ie,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              stat_wr,
  input  logic [1:0]        flag_wdata,
  input  logic              sw_fill,
  input  logic              sw_free,
  input  logic              eng_out_sent,
  input  logic              eng_in_rcvd,
  input  logic              eng_in_pid,
  input  logic              eng_ack,
  output logic [STAT_W-1:0] stat_rd,
  output logic [CNT_W-1:0]  cnt_rd,
  output logic [PTR_W-1:0]  eng_bank,
  output logic [PTR_W-1:0]  sw_bank,
  output logic              bank_empty,
  output logic              tok_allow,
  output logic              irq
);
  logic [BUSY_W-1:0] busy;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              empty, full, tgl, frozen;
  pend_e             pend_q, pend_d, out_kind;
  logic              pid_q, uf_q, uf_d, uf_set, irq_q;
  logic              out_ev, in_ev, ack_ev;
  logic              out_done, out_data_done, in_done;
  logic              bank_inc, bank_dec, uf_clr, frz_clr;

  // engine events are dropped entirely while frozen
  assign out_ev = eng_out_sent && !cfg_dir_in && !frozen;
  assign in_ev  = eng_in_rcvd  &&  cfg_dir_in && !frozen;
  assign ack_ev = eng_ack && !frozen;

  always_comb begin
    if (!empty)            out_kind = PEND_DATA;
    else if (cfg_periodic) out_kind = PEND_ZERO;
    else                   out_kind = PEND_NONE;
  end

  always_comb begin
    if (out_ev)      pend_d = out_kind;
    else if (in_ev)  pend_d = full ? PEND_NONE : PEND_DATA;
    else if (ack_ev) pend_d = PEND_NONE;
    else             pend_d = pend_q;
  end

  assign out_done      = ack_ev && !cfg_dir_in && (pend_q != PEND_NONE);
  assign out_data_done = ack_ev && !cfg_dir_in && (pend_q == PEND_DATA);
  assign in_done       = ack_ev &&  cfg_dir_in && (pend_q == PEND_DATA);

  assign bank_inc = (!cfg_dir_in && sw_fill) || in_done;
  assign bank_dec = out_data_done || (cfg_dir_in && sw_free);

  assign uf_set  = out_ev && (out_kind == PEND_ZERO);
  assign uf_clr  = stat_wr && !flag_wdata[0];
  assign frz_clr = stat_wr && !flag_wdata[1];
  assign uf_d    = uf_set || (uf_q && !uf_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= PEND_NONE;
      pid_q  <= 1'b0;
      uf_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (in_ev) pid_q <= eng_in_pid;
      uf_q   <= uf_d;
      irq_q  <= uf_d && cfg_ie;
    end
  end

  hpipe_bank_track #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk(clk), .rst(rst), .inc(bank_inc), .dec(bank_dec),
    .busy(busy), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .empty(empty), .full(full)
  );

  hpipe_toggle u_tgl (
    .clk(clk), .rst(rst), .dir_in(cfg_dir_in), .out_adv(out_done),
    .in_load(in_done), .in_pid(pid_q), .tgl(tgl)
  );

  hpipe_inreq_ctr #(.CNT_W(CNT_W)) u_req (
    .clk(clk), .rst(rst), .load(cnt_wr), .load_val(cnt_wdata),
    .step(in_done), .frz_clr(frz_clr), .cnt(cnt_rd), .frozen(frozen)
  );

  always_comb begin
    stat_rd               = '0;
    stat_rd[1:0]          = 2'(busy);
    stat_rd[2]            = tgl;
    stat_rd[STAT_UF_BIT]  = uf_q;
    stat_rd[STAT_FRZ_BIT] = frozen;
  end

  assign eng_bank   = cfg_dir_in ? wr_ptr : rd_ptr;
  assign sw_bank    = cfg_dir_in ? rd_ptr : wr_ptr;
  assign bank_empty = empty;
  assign tok_allow  = !frozen;
  assign irq        = irq_q;

  // R9: underflow stays set unless software writes 0 to it
  p_uf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (uf_q && !uf_clr) |=> uf_q);
  // R8: no interrupt without the flag
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> uf_q);
  // R11: a frozen pipe holds its toggle
  p_frz_hold_r11: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(tgl));
  // R7: an empty periodic OUT data phase raises underflow
  p_uf_on_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (out_ev && empty && cfg_periodic) |=> uf_q);
endmodule

// File: tb/tb_hpipe_bank_ctrl.sv
module tb_hpipe_bank_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_dir_in = 0, cfg_periodic = 0, cfg_ie = 0;
  logic       cnt_wr = 0;
  logic [7:0] cnt_wdata = '0;
  logic       stat_wr = 0;
  logic [1:0] flag_wdata = '0;
  logic       sw_fill = 0, sw_free = 0;
  logic       eng_out_sent = 0, eng_in_rcvd = 0, eng_in_pid = 0, eng_ack = 0;
  logic [7:0] stat_rd;
  logic [7:0] cnt_rd;
  logic       eng_bank, sw_bank, bank_empty, tok_allow, irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hpipe_bank_ctrl dut (
    .clk(clk), .rst(rst), .cfg_dir_in(cfg_dir_in), .cfg_periodic(cfg_periodic),
    .cfg_ie(cfg_ie), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .stat_wr(stat_wr),
    .flag_wdata(flag_wdata), .sw_fill(sw_fill), .sw_free(sw_free),
    .eng_out_sent(eng_out_sent), .eng_in_rcvd(eng_in_rcvd), .eng_in_pid(eng_in_pid),
    .eng_ack(eng_ack), .stat_rd(stat_rd), .cnt_rd(cnt_rd), .eng_bank(eng_bank),
    .sw_bank(sw_bank), .bank_empty(bank_empty), .tok_allow(tok_allow), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: pend 0 none, 1 data, 2 zero-length
  int m_busy, m_wr, m_rd, m_tgl, m_uf, m_frz, m_cnt, m_irq, m_pend, m_pid;
  int a, oe, ie_, ae, kind, inc, dec, idone, odone, oddone, n_uf;
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_wr = 0; m_rd = 0; m_tgl = 0; m_uf = 0;
      m_frz = 0; m_cnt = 0; m_irq = 0; m_pend = 0; m_pid = 0;
    end else begin
      a   = !m_frz;
      oe  = eng_out_sent && !cfg_dir_in && a;
      ie_ = eng_in_rcvd && cfg_dir_in && a;
      ae  = eng_ack && a;
      kind   = (m_busy > 0) ? 1 : (cfg_periodic ? 2 : 0);
      odone  = ae && !cfg_dir_in && m_pend != 0;
      oddone = ae && !cfg_dir_in && m_pend == 1;
      idone  = ae && cfg_dir_in && m_pend == 1;
      inc = ((!cfg_dir_in && sw_fill) || idone) && m_busy < 2;
      dec = (oddone || (cfg_dir_in && sw_free)) && m_busy > 0;
      if (odone) m_tgl = 1 - m_tgl;
      else if (idone) m_tgl = m_pid;
      if (inc) m_wr = (m_wr + 1) % 2;
      if (dec) m_rd = (m_rd + 1) % 2;
      n_uf = (oe && kind == 2) || (m_uf && !(stat_wr && !flag_wdata[0]));
      if (idone && m_cnt == 0) m_frz = 1;
      else if (stat_wr && !flag_wdata[1]) m_frz = 0;
      if (cnt_wr) m_cnt = cnt_wdata;
      else if (idone && m_cnt > 0) m_cnt = m_cnt - 1;
      if (oe) m_pend = kind;
      else if (ie_) m_pend = (m_busy == 2) ? 0 : 1;
      else if (ae) m_pend = 0;
      if (ie_) m_pid = eng_in_pid;
      m_busy = m_busy + inc - dec;
      m_uf = n_uf;
      m_irq = n_uf && cfg_ie;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 busy", stat_rd[1:0], m_busy);
      chk("R4 toggle", stat_rd[3:2], m_tgl);
      chk("R7 underflow", stat_rd[5], m_uf);
      chk("R11 frozen", stat_rd[6], m_frz);
      chk("R12 reserved", {stat_rd[7], stat_rd[4]}, 0);
      chk("R8 irq", irq, m_irq);
      chk("R10 count", cnt_rd, m_cnt);
      chk("R11 tok_allow", tok_allow, !m_frz);
      chk("R2 eng_bank", eng_bank, cfg_dir_in ? m_wr : m_rd);
      chk("R3 sw_bank", sw_bank, cfg_dir_in ? m_rd : m_wr);
      chk("R7 bank_empty", bank_empty, m_busy == 0);
    end
  end

  task automatic cyc();
    @(negedge clk);
    cnt_wr = 0; stat_wr = 0; sw_fill = 0; sw_free = 0;
    eng_out_sent = 0; eng_in_rcvd = 0; eng_ack = 0;
  endtask

  task automatic out_xfer(input bit ack);
    eng_out_sent = 1; cyc();
    if (ack) begin eng_ack = 1; cyc(); end
  endtask

  task automatic in_xfer(input bit pid);
    eng_in_rcvd = 1; eng_in_pid = pid; cyc();
    eng_ack = 1; cyc();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
    end
  end

  initial begin
    cfg_periodic = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    cyc();
    chk("R12 reset status", stat_rd, 0);
    chk("R12 reset tok_allow", tok_allow, 1);
    chk("R4 reset toggle", stat_rd[3:2], 0);

    // OUT pipe, periodic, nothing filled
    out_xfer(0);
    chk("R7 underflow on empty", stat_rd[5], 1);
    chk("R7 busy unchanged", stat_rd[1:0], 0);
    chk("R8 irq off when disabled", irq, 0);
    eng_ack = 1; cyc();
    chk("R5 zero-length ack flips", stat_rd[3:2], 1);
    cfg_ie = 1; cyc();
    chk("R8 irq with enable", irq, 1);
    stat_wr = 1; flag_wdata = 2'b11; cyc();
    chk("R9 write 1 no effect", stat_rd[5], 1);
    stat_wr = 1; flag_wdata = 2'b00; cyc();
    chk("R9 write 0 clears", stat_rd[5], 0);
    chk("R8 irq drops", irq, 0);

    sw_fill = 1; cyc();
    chk("R2 one fill", stat_rd[1:0], 1);
    chk("R2 sw_bank advances", sw_bank, 1);
    sw_fill = 1; cyc();
    sw_fill = 1; cyc();
    chk("R1 saturates at two", stat_rd[1:0], 2);
    chk("R2 sw_bank wraps", sw_bank, 0);
    out_xfer(1);
    chk("R2 ack releases bank", stat_rd[1:0], 1);
    chk("R2 eng_bank advances", eng_bank, 1);
    chk("R5 data ack flips", stat_rd[3:2], 0);
    out_xfer(0);
    cyc();
    chk("R5 no ack no flip", stat_rd[3:2], 0);
    eng_ack = 1; cyc();
    chk("R2 second release", stat_rd[1:0], 0);
    chk("R5 late ack flips", stat_rd[3:2], 1);

    cfg_periodic = 0;
    out_xfer(1);
    chk("R7 non-periodic no flag", stat_rd[5], 0);
    chk("R7 non-periodic no flip", stat_rd[3:2], 1);
    cfg_periodic = 1;
    eng_out_sent = 1; stat_wr = 1; flag_wdata = 2'b00; cyc();
    chk("R9 hardware set wins", stat_rd[5], 1);
    eng_ack = 1; cyc();

    // IN pipe
    rst = 1; cfg_dir_in = 1; cfg_ie = 0;
    cyc(); cyc();
    rst = 0;
    cnt_wr = 1; cnt_wdata = 8'd2; cyc();
    chk("R10 count loaded", cnt_rd, 2);
    in_xfer(1);
    chk("R3 IN fills bank", stat_rd[1:0], 1);
    chk("R6 toggle DATA1", stat_rd[3:2], 1);
    chk("R10 count down", cnt_rd, 1);
    chk("R3 eng_bank advances", eng_bank, 1);
    in_xfer(0);
    chk("R6 toggle DATA0", stat_rd[3:2], 0);
    chk("R10 count at zero", cnt_rd, 0);
    chk("R11 not yet frozen", tok_allow, 1);
    in_xfer(1);
    chk("R3 full drops busy", stat_rd[1:0], 2);
    chk("R3 full drops toggle", stat_rd[3:2], 0);
    chk("R3 full keeps freeze off", stat_rd[6], 0);
    sw_free = 1; cyc();
    chk("R3 free releases", stat_rd[1:0], 1);
    chk("R3 sw_bank advances", sw_bank, 1);
    in_xfer(1);
    chk("R10 freeze after N+1", stat_rd[6], 1);
    chk("R11 tokens withheld", tok_allow, 0);
    chk("R6 last toggle", stat_rd[3:2], 1);
    in_xfer(0);
    chk("R11 frozen ignores toggle", stat_rd[3:2], 1);
    chk("R11 frozen ignores busy", stat_rd[1:0], 2);
    stat_wr = 1; flag_wdata = 2'b11; cyc();
    chk("R9 freeze write 1 no effect", stat_rd[6], 1);
    stat_wr = 1; flag_wdata = 2'b01; cyc();
    chk("R11 freeze cleared", tok_allow, 1);
    sw_free = 1; cyc();
    sw_free = 1; cyc();
    sw_free = 1; cyc();
    chk("R1 free on empty ignored", stat_rd[1:0], 0);
    cyc();
    done = 1;
    summary();
  end
endmodule